// File: doc/BRIEF.md
# Shadowed Phase-Accumulator PWM Generator

This block drives one pulse-width-modulated output from a single 32-bit control word on a plain write/read port. On every clock it adds a programmable step to an N-bit phase accumulator. Each time the accumulator wraps, one output period ends. The output frequency is therefore step × f_clk / 2^N, and a step of zero produces no periods at all. The output is high while the top eight accumulator bits exceed an 8-bit divisor. The high fraction of a period is thus roughly (255 − divisor)/255, and a divisor of 255 holds the line low.

Software writes the step and divisor into a shadow copy, which has no effect on the running waveform. It then writes the same word again with the request bit set. The hardware copies the shadow into the active configuration at the next period boundary and clears the request bit there. While a request is pending, the shadow fields and the request bit are locked against writes. The enable bit stays writable during that time. A disabled block counts as a permanent boundary, so a pending request is always applied and cleared, even when the active step is zero. Disabling also holds the accumulator at zero and drives the output low, so every enable starts a fresh period from phase zero.

Top module: `pwm_shadow`

## Requirements
- R1: After reset, rd_data reads 0 and pwm_o is low.
- R2: Control word layout: bit 31 = enable, bit 30 = update request, bits 8+N-1:8 = step, bits 7:0 = divisor. A read returns the shadow step and divisor, the live enable and request bits, and zeros in bits 29 down to 8+N.
- R3: With an active step s, the output completes one period every 2^N/s clocks (for s a power of two). With an active step of 0, the block never wraps and the output stays low.
- R4: The output is high in exactly those clocks of a period whose top eight accumulator bits exceed the divisor. For N=8 and step s, that is P − (d/s + 1) high clocks per period of P = 256/s, or 0 if that value is not positive. A divisor of 255 gives a constant low output.
- R5: A step or divisor written without the request bit changes the read-back shadow only. The waveform keeps its previous configuration.
- R6: A set request bit is cleared by hardware at the next period boundary, and the shadow becomes active there.
- R7: While the request bit is set, writes leave the step, divisor and request bit unchanged. Only the enable bit is updated.
- R8: While enable is low, the accumulator is held at zero and the output is low. Each disabled clock counts as a boundary for a pending request. The register contents remain readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word read-back |
| pwm_o | output | 1 | PWM output (registered) |

## Verification
A write is captured on the clock edge where wr_en is high, and its effect on rd_data shows at that same edge. The bench therefore reads back at the falling edge that follows. The output is registered one stage behind the accumulator, and a pending request takes effect on the edge where the accumulator wraps. For this reason the duty and frequency checks do not try to align to a given edge. After a few settling clocks, they count high clocks over exactly one period and rising edges over four periods. Both counts are the same whatever the window's phase. The request-clear check reads the bit right after the write and again after more than one old period has elapsed.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int EN_BIT   = 31;
  localparam int REQ_BIT  = 30;
  localparam int DIV_W    = 8;
  localparam int STEP_LSB = 8;
endpackage

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] step,
  output logic [W-1:0] phase,
  output logic         wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, step};
  assign wrap = run & sum[W];

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= sum[W-1:0];
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0));

  // R3
  no_step_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |-> !wrap);
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int W  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [W-1:0]  phase,
  input  logic [DW-1:0] thresh,
  output logic          pwm_o
);
  logic [DW-1:0] top_bits;

  assign top_bits = phase[W-1 -: DW];

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= run && (top_bits > thresh);
  end

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_o);

  // R4
  max_div_low_chk: assert property (@(posedge clk) disable iff (rst)
    (thresh == {DW{1'b1}}) |=> !pwm_o);
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_shadow_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             boundary,
  output logic             en_o,
  output logic             req_o,
  output logic [N-1:0]     act_step,
  output logic [DIV_W-1:0] act_div,
  output logic [31:0]      rd_data
);
  logic [N-1:0]     sh_step;
  logic [DIV_W-1:0] sh_div;
  logic             open_wr;

  assign open_wr = wr_en && !req_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= 1'b0;
      req_o    <= 1'b0;
      sh_step  <= '0;
      sh_div   <= '0;
      act_step <= '0;
      act_div  <= '0;
    end else begin
      if (wr_en) en_o <= wr_data[EN_BIT];
      if (open_wr) begin
        sh_step <= wr_data[STEP_LSB +: N];
        sh_div  <= wr_data[DIV_W-1:0];
      end
      if (req_o && boundary) begin
        act_step <= sh_step;
        act_div  <= sh_div;
        req_o    <= 1'b0;
      end else if (open_wr) begin
        req_o <= wr_data[REQ_BIT];
      end
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[EN_BIT]         = en_o;
    rd_data[REQ_BIT]        = req_o;
    rd_data[STEP_LSB +: N]  = sh_step;
    rd_data[DIV_W-1:0]      = sh_div;
  end

  generate
    if (STEP_LSB + N < REQ_BIT) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^wr_data[REQ_BIT-1:STEP_LSB+N];
    end
  endgenerate

  // R6
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && boundary) |=> !req_o);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> ($stable(sh_step) && $stable(sh_div)));

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_o && boundary) |=> ($stable(act_step) && $stable(act_div)));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_shadow_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_o
);
  logic              en;
  logic              req;
  logic [STEP_W-1:0] act_step;
  logic [DIV_W-1:0]  act_div;
  logic [STEP_W-1:0] phase;
  logic              wrap;
  logic              boundary;

  assign boundary = wrap || !en;

  pwm_cfg_regs #(.N(STEP_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .boundary (boundary),
    .en_o     (en),
    .req_o    (req),
    .act_step (act_step),
    .act_div  (act_div),
    .rd_data  (rd_data)
  );

  pwm_phase_acc #(.W(STEP_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .run   (en),
    .step  (act_step),
    .phase (phase),
    .wrap  (wrap)
  );

  pwm_cmp #(.W(STEP_W), .DW(DIV_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .run    (en),
    .phase  (phase),
    .thresh (act_div),
    .pwm_o  (pwm_o)
  );

  // R8
  idle_clears_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && req) |=> !req);
endmodule

// File: tb/test_pwm_shadow.sv
module test_pwm_shadow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_o;
  int          nvec = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwm_shadow #(.STEP_W(8)) i_pwm_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_o(pwm_o)
  );

  function automatic logic [31:0] mk(bit en, bit req, logic [7:0] s, logic [7:0] d);
    return {en, req, 14'b0, s, d};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(int p, int exp_hi, string tag);
    int hi = 0, edges = 0;
    logic prev;
    idle(3);
    for (int i = 0; i < p; i++) begin @(negedge clk); if (pwm_o) hi++; end
    chk({tag, " R4 high clocks"}, hi, exp_hi);
    prev = pwm_o;
    for (int i = 0; i < 4 * p; i++) begin
      @(negedge clk);
      if (pwm_o && !prev) edges++;
      prev = pwm_o;
    end
    chk({tag, " R3 periods"}, edges, (exp_hi > 0) ? 4 : 0);
  endtask

  function automatic int exp_high(int s, int d);
    int p = 256 / s;
    int v = p - (d / s + 1);
    return (v > 0) ? v : 0;
  endfunction

  initial begin
    int divs[8] = '{0, 1, 37, 127, 128, 200, 254, 255};
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pwm_o", pwm_o, 0);

    // R3/R7: step 0 active, request stays pending, writes locked
    wr(mk(1, 1, 8'd0, 8'd0));
    idle(20);
    chk("R3 step0 output low", pwm_o, 0);
    chk("R6 request held without wrap", rd_data[30], 1);
    wr(mk(1, 0, 8'd64, 8'd10));
    chk("R7 locked write", rd_data, mk(1, 1, 8'd0, 8'd0));
    // R8: disabling is a boundary
    wr(mk(0, 0, 8'd64, 8'd10));
    @(negedge clk);
    chk("R8 disable clears request", rd_data, mk(0, 0, 8'd0, 8'd0));

    // R2: field layout and spare bits
    wr(32'hFFFF_FFFF);
    chk("R2 read layout", rd_data, 32'hC000_FFFF);
    wr(mk(0, 0, 8'd0, 8'd0));
    idle(2);

    // R4/R3 sweep: update while disabled, then enable
    for (int si = 0; si < 8; si++) begin
      for (int di = 0; di < 8; di++) begin
        int s = 1 << si;
        wr(mk(0, 0, s[7:0], divs[di][7:0]));
        wr(mk(0, 1, s[7:0], divs[di][7:0]));
        wr(mk(1, 0, s[7:0], divs[di][7:0]));
        chk("R2 sweep readback", rd_data, mk(1, 0, s[7:0], divs[di][7:0]));
        measure(256 / s, exp_high(s, divs[di]), $sformatf("s=%0d d=%0d", s, divs[di]));
      end
    end

    // R5: shadow write without request leaves waveform alone
    wr(mk(0, 0, 8'd64, 8'd100));
    wr(mk(0, 1, 8'd64, 8'd100));
    wr(mk(1, 0, 8'd64, 8'd100));
    wr(mk(1, 0, 8'd32, 8'd50));
    chk("R5 shadow readback", rd_data, mk(1, 0, 8'd32, 8'd50));
    measure(4, exp_high(64, 100), "R5 old config kept");
    // R6: request while running, cleared at next wrap
    wr(mk(1, 1, 8'd32, 8'd50));
    chk("R6 request visible", rd_data[30], 1);
    idle(6);
    chk("R6 request self-cleared", rd_data[30], 0);
    measure(8, exp_high(32, 50), "R6 new config");

    // R8: disable stops output, contents kept
    wr(mk(0, 0, 8'd32, 8'd50));
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_o) hi++; end
      chk("R8 disabled output low", hi, 0);
    end
    chk("R8 contents readable", rd_data, mk(0, 0, 8'd32, 8'd50));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule